// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

An 8-bit arithmetic and logic unit for a small processor datapath. Two operands and a 4-bit operation code go in; the 8-bit result, a write-back strobe and a six-bit status word come out. The result is combinational. The status word is a register inside the block, and the carry-in used by the carry-chained operations is the carry bit of that register.

Every operation rewrites only its own group of flags, and the other flags keep their stored values. The carry-chained subtract and compare keep the zero flag "sticky": zero can only stay set or be cleared. This lets a multi-byte equality test run one byte at a time, low byte first. A compare runs the subtraction and updates the flags, but it drops the write-back strobe so the difference is never stored.

Flag word bit positions: bit 0 carry C, bit 1 zero Z, bit 2 negative N, bit 3 overflow V, bit 4 sign S, bit 5 half-carry H. Operation codes are given inside each requirement.

Top module: `alu8_flagged`

## Requirements
- R1: A synchronous active-high reset clears the whole flag word to 0.
- R2: Add (code 0) and add-with-carry (code 1, adds the stored C) output a+b(+C) and update all flags: C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R3: Subtract (code 2) and subtract-with-carry (code 3, also subtracts the stored C) output a-b(-C) and update all flags: C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow.
- R4: For codes 3 and 12, Z becomes 0 when the result is nonzero and otherwise keeps its stored value.
- R5: AND (code 4), OR (code 5) and XOR (code 6) update Z, N, S and force V to 0. C and H are unchanged.
- R6: One's complement (code 7) outputs 0xFF-a, sets C to 1, forces V to 0, updates Z, N and S, and leaves H unchanged.
- R7: Negate (code 8) outputs 0x00-a and updates all flags as a subtraction from zero. C is 1 exactly when a is nonzero, and V is 1 exactly when a is 0x80.
- R8: Increment (code 9) and decrement (code 10) output a+1 and a-1 and update Z, N, V and S. V is 1 only for 0x7F (increment) or 0x80 (decrement). C and H are unchanged.
- R9: Compare (code 11) and compare-with-carry (code 12) put the difference on the result port and update flags exactly as codes 2 and 3, but hold the write-back strobe low. Every other valid code raises the strobe.
- R10: After any update, S equals N XOR V.
- R11: The flags change only on a clock edge with the enable high and a valid code. Codes 13 to 15 leave the flags unchanged and give result 0 with the strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Operation is issued this cycle; flags update at the edge |
| op_sel | input | 4 | Operation code |
| opd_a | input | 8 | First operand (the only operand for one-operand codes) |
| opd_b | input | 8 | Second operand |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 6 | Registered flag word {H,S,V,N,Z,C} |

## Verification
The assertions watch the flag register on every cycle. They check that S stays consistent with N and V, that the flags hold when nothing is issued, and that logic ops, increment and decrement keep C and H while the complement forces C. They also check that a cleared Z is never set again by a chained subtract or compare. The arithmetic values themselves (sums, borrows, half-carries, overflow corners, 0x80 negation and sticky-Z chains from a preloaded Z of both 0 and 1) can only be shown by the bench's vectors, which preload the flags before each operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_N = 6;

  // operation codes
  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_COM = 4'd7;
  localparam logic [3:0] OP_NEG = 4'd8;
  localparam logic [3:0] OP_INC = 4'd9;
  localparam logic [3:0] OP_DEC = 4'd10;
  localparam logic [3:0] OP_CMP = 4'd11;
  localparam logic [3:0] OP_CPC = 4'd12;

  // packed: c is bit 0, h is bit 5
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  localparam flags_t MASK_ALL   = flags_t'(6'b111111);
  localparam flags_t MASK_ZCNVS = flags_t'(6'b011111);
  localparam flags_t MASK_ZNVS  = flags_t'(6'b011110);
  localparam flags_t MASK_NONE  = flags_t'(6'b000000);
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         co,
  output logic         hc,
  output logic         ov
);
  logic [W:0]  wide;
  logic [HB:0] low;

  always_comb begin
    if (sub) begin
      wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
      low  = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, cin};
    end else begin
      wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
      low  = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, cin};
    end
    sum = wide[W-1:0];
    co  = wide[W];
    hc  = low[HB];
    if (sub) ov = (x[W-1] != y[W-1]) && (wide[W-1] != x[W-1]);
    else     ov = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cur_c,
  input  logic         cur_z,
  output logic [W-1:0] res,
  output flags_t       nxt,
  output flags_t       upd,
  output logic         wr
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] x, y, sum;
  logic         cin, sub, co, hc, ov, zero;

  // operand routing into the shared adder/subtractor
  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    sub = 1'b0;
    case (op)
      OP_ADC:         cin = cur_c;
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_SBC, OP_CPC: begin sub = 1'b1; cin = cur_c; end
      OP_NEG:         begin x = '0; y = a; sub = 1'b1; end
      OP_INC:         y = ONE;
      OP_DEC:         begin y = ONE; sub = 1'b1; end
      default:        ;
    endcase
  end

  alu8_addsub #(.W(W), .HB(HB)) i_addsub (
    .x(x), .y(y), .cin(cin), .sub(sub),
    .sum(sum), .co(co), .hc(hc), .ov(ov)
  );

  // result, write strobe and per-op flag group
  always_comb begin
    res   = sum;
    wr    = 1'b1;
    upd   = MASK_ALL;
    nxt.c = co;
    nxt.h = hc;
    nxt.v = ov;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: ;
      OP_CMP, OP_CPC: wr = 1'b0;
      OP_AND: begin res = a & b; upd = MASK_ZNVS; nxt.v = 1'b0; end
      OP_OR:  begin res = a | b; upd = MASK_ZNVS; nxt.v = 1'b0; end
      OP_XOR: begin res = a ^ b; upd = MASK_ZNVS; nxt.v = 1'b0; end
      OP_COM: begin
        res   = ~a;
        upd   = MASK_ZCNVS;
        nxt.c = 1'b1;
        nxt.v = 1'b0;
      end
      OP_INC, OP_DEC: upd = MASK_ZNVS;
      default: begin res = '0; wr = 1'b0; upd = MASK_NONE; end
    endcase
    zero  = (res == '0);
    nxt.n = res[W-1];
    nxt.s = nxt.n ^ nxt.v;
    if (op == OP_SBC || op == OP_CPC) nxt.z = zero & cur_z;
    else                              nxt.z = zero;
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [NF-1:0] d,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= (d & mask) | (q & ~mask);
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (q == '0))
    else $error("flag word not cleared by reset");

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q))
    else $error("flags changed without an update");
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_en,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [FLAG_N-1:0] flags_o
);
  flags_t flags_q, nxt, upd;
  logic [FLAG_N-1:0] q_raw;

  alu8_core #(.W(W), .HB(HB)) i_core (
    .op(op_sel), .a(opd_a), .b(opd_b),
    .cur_c(flags_q.c), .cur_z(flags_q.z),
    .res(result_o), .nxt(nxt), .upd(upd), .wr(wr_en_o)
  );

  alu8_flagreg #(.NF(FLAG_N)) i_flagreg (
    .clk(clk), .rst(rst), .en(op_en),
    .d(nxt), .mask(upd), .q(q_raw)
  );

  assign flags_q = flags_t'(q_raw);
  assign flags_o = q_raw;

  assert_sign_parity_R10: assert property (@(posedge clk) disable iff (rst)
    flags_q.s == (flags_q.n ^ flags_q.v))
    else $error("S differs from N xor V");

  assert_sticky_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (op_en && (op_sel == OP_SBC || op_sel == OP_CPC) && !flags_q.z) |=> !flags_q.z)
    else $error("chained op set Z again");

  assert_logic_keeps_ch_R5: assert property (@(posedge clk) disable iff (rst)
    (op_en && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR))
    |=> (flags_q.c == $past(flags_q.c) && flags_q.h == $past(flags_q.h) && !flags_q.v))
    else $error("logic op disturbed C/H or left V set");

  assert_com_forces_c_R6: assert property (@(posedge clk) disable iff (rst)
    (op_en && op_sel == OP_COM) |=> (flags_q.c && flags_q.h == $past(flags_q.h)))
    else $error("complement did not set C or changed H");

  assert_incdec_keeps_ch_R8: assert property (@(posedge clk) disable iff (rst)
    (op_en && (op_sel == OP_INC || op_sel == OP_DEC))
    |=> (flags_q.c == $past(flags_q.c) && flags_q.h == $past(flags_q.h)))
    else $error("increment/decrement disturbed C/H");
endmodule

// File: tb/test_alu8_flagged.sv
module test_alu8_flagged;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_en = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] opd_a = '0, opd_b = '0;
  logic [7:0] result_o;
  logic       wr_en_o;
  logic [5:0] flags_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] res_s;
  logic       wr_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flagged i_alu8_flagged (
    .clk(clk), .rst(rst), .op_en(op_en), .op_sel(op_sel),
    .opd_a(opd_a), .opd_b(opd_b),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  // {op[4], preset[3], a[8], b[8], result[8], flags{H,S,V,N,Z,C}[6], wr[1]}
  // presets: 0 C0Z1H0  1 C0Z0H0  2 C1Z0H0  3 C1Z1H0  4 C1Z0H1(V1,S1)
  localparam logic [37:0] VEC [NV] = '{
    {4'd0, 3'd0, 8'h3A, 8'h46, 8'h80, 6'b101100, 1'b1}, // R2 H, V
    {4'd0, 3'd0, 8'hC0, 8'h40, 8'h00, 6'b000011, 1'b1}, // R2 carry out
    {4'd1, 3'd2, 8'hFF, 8'h00, 8'h00, 6'b100011, 1'b1}, // R2 carry in
    {4'd1, 3'd4, 8'h7F, 8'h00, 8'h80, 6'b101100, 1'b1}, // R2
    {4'd2, 3'd0, 8'h10, 8'h01, 8'h0F, 6'b100000, 1'b1}, // R3 half borrow
    {4'd2, 3'd0, 8'h80, 8'h01, 8'h7F, 6'b111000, 1'b1}, // R3 overflow
    {4'd3, 3'd3, 8'h05, 8'h05, 8'hFF, 6'b110101, 1'b1}, // R3 borrow in
    {4'd3, 3'd3, 8'h06, 8'h05, 8'h00, 6'b000010, 1'b1}, // R4 Z kept 1
    {4'd3, 3'd2, 8'h06, 8'h05, 8'h00, 6'b000000, 1'b1}, // R4 Z kept 0
    {4'd3, 3'd2, 8'h00, 8'h7F, 8'h80, 6'b110101, 1'b1}, // R3
    {4'd4, 3'd4, 8'hF0, 8'h8F, 8'h80, 6'b110101, 1'b1}, // R5
    {4'd5, 3'd0, 8'h00, 8'h00, 8'h00, 6'b000010, 1'b1}, // R5
    {4'd6, 3'd4, 8'hAA, 8'hAA, 8'h00, 6'b100011, 1'b1}, // R5
    {4'd7, 3'd4, 8'h7F, 8'h00, 8'h80, 6'b110101, 1'b1}, // R6
    {4'd8, 3'd0, 8'h80, 8'h00, 8'h80, 6'b001101, 1'b1}, // R7
    {4'd8, 3'd0, 8'h01, 8'h00, 8'hFF, 6'b110101, 1'b1}, // R7
    {4'd8, 3'd1, 8'h00, 8'h00, 8'h00, 6'b000010, 1'b1}, // R7 zero
    {4'd9, 3'd4, 8'h7F, 8'h00, 8'h80, 6'b101101, 1'b1}, // R8
    {4'd9, 3'd4, 8'hFF, 8'h00, 8'h00, 6'b100011, 1'b1}, // R8
    {4'd10, 3'd0, 8'h80, 8'h00, 8'h7F, 6'b011000, 1'b1}, // R8
    {4'd10, 3'd4, 8'h01, 8'h00, 8'h00, 6'b100011, 1'b1}, // R8
    {4'd11, 3'd0, 8'h10, 8'h20, 8'hF0, 6'b010101, 1'b0}, // R9
    {4'd11, 3'd1, 8'h42, 8'h42, 8'h00, 6'b000010, 1'b0}, // R9
    {4'd12, 3'd3, 8'h43, 8'h42, 8'h00, 6'b000010, 1'b0}, // R9 R4
    {4'd12, 3'd2, 8'h43, 8'h42, 8'h00, 6'b000000, 1'b0}  // R9 R4
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, sample result 1 time unit later, flags after the edge
  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_en = 1'b1; op_sel = op; opd_a = a; opd_b = b;
    #1;
    res_s = result_o;
    wr_s  = wr_en_o;
    @(negedge clk);
    op_en = 1'b0;
  endtask

  task automatic preset(input logic [2:0] k);
    apply(4'd0, 8'h00, 8'h00);
    case (k)
      3'd1: apply(4'd0, 8'h01, 8'h00);
      3'd2: apply(4'd7, 8'h00, 8'h00);
      3'd3: apply(4'd7, 8'hFF, 8'h00);
      3'd4: apply(4'd0, 8'h8F, 8'h81);
      default: ;
    endcase
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3/R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      default: return "R9/R4";
    endcase
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "flags after reset", 32'(flags_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      preset(v[33:31]);
      apply(v[37:34], v[30:23], v[22:15]);
      check(req_of(v[37:34]), $sformatf("result vec %0d", i), 32'(res_s), 32'(v[14:7]));
      check("R9", $sformatf("write strobe vec %0d", i), 32'(wr_s), 32'(v[0]));
      check(req_of(v[37:34]), $sformatf("flags vec %0d", i), 32'(flags_o), 32'(v[6:1]));
      check("R10", $sformatf("S parity vec %0d", i), 32'(flags_o[4]),
            32'(flags_o[2] ^ flags_o[3]));
    end

    // R11: enable low leaves flags alone
    preset(3'd4);
    @(negedge clk);
    op_sel = 4'd0; opd_a = 8'hFF; opd_b = 8'hFF; op_en = 1'b0;
    @(negedge clk);
    check("R11", "flags with enable low", 32'(flags_o), 32'h39);

    // R11: reserved code with enable high
    apply(4'd14, 8'h12, 8'h34);
    check("R11", "reserved result", 32'(res_s), 32'h0);
    check("R11", "reserved strobe", 32'(wr_s), 32'h0);
    check("R11", "reserved flags", 32'(flags_o), 32'h39);

    // R1: reset mid-run clears a nonzero flag word
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "flags after second reset", 32'(flags_o), 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule